// File: doc/BRIEF.md
# Four-Lane Vector Adder on Two-Port Memories

This block sums two integer vectors element by element. Each operand vector and the result vector lives in its own local memory of `DEPTH` words (1024 by default), and every memory has exactly two access ports. The datapath has `LANES` parallel adder lanes (four by default). Each outer iteration therefore covers four consecutive elements, and a default run has 256 iterations. Only two words of one memory can move per cycle. So each iteration issues its operand reads in two back-to-back cycles, and its result writes land in two back-to-back cycles. The upper pair of lanes runs one cycle behind the lower pair.

While the block is idle, a host loads both operand memories and reads the result memory back through one shared address/data port. It then pulses `start`, waits for the one-cycle `done`, and reads the sums. A cycle counter reports the length of the run so the iteration cost can be checked from outside.

Control is a four-state machine:
- `S_IDLE` waits for a start.
- `S_ISSUE` spends one cycle per lane pair, issuing reads.
- `S_DRAIN` waits for the adder pipeline and the writes.
- `S_FIN` raises `done`.

Its transitions are:
- IDLE→ISSUE on `start`.
- ISSUE→DRAIN after the last lane pair is issued.
- DRAIN→ISSUE at the end of an iteration that is not the final one.
- DRAIN→FIN at the end of the final iteration.
- FIN→IDLE unconditionally.

Top module: `lane4_vadd`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `lat_cycles` is 0.
- R2: After a run, result word i equals operand-A word i plus operand-B word i for every i in 0..1023, including the first lane pair of every group (i mod 4 in {0,1}).
- R3: In iteration k, elements 4k and 4k+1 are read in its first cycle and elements 4k+2 and 4k+3 in its second. Each iteration takes ADD_LAT+3 cycles (11 with the default ADD_LAT of 8), and `lat_cycles` reads 256*11 = 2816 when `done` is high.
- R4: Results 4k and 4k+1 are written in iteration cycle ADD_LAT+1 and results 4k+2 and 4k+3 in cycle ADD_LAT+2. A memory port never carries two writes in one cycle, and the late-pair elements (i mod 4 in {2,3}) hold correct sums.
- R5: `busy` is 1 from the clock edge that samples `start` until `done`. `done` is 1 for exactly one cycle and appears 2816 clock edges after the edge that sampled `start`. Iterations never overlap.
- R6: A `start` pulse while `busy` is 1 has no effect: `done` timing and `lat_cycles` are unchanged.
- R7: Host writes to the operand memories while `busy` is 1 are discarded.
- R8: Sums wrap modulo 2^32 (carry out is dropped).
- R9: After `done`, a new `start` performs a full new run on the current memory contents and gives the same results.
- R10: While idle, `host_rdata` shows result word `host_addr` one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| host_wr_a | input | 1 | Write `host_wdata` into operand A at `host_addr` (idle only) |
| host_wr_b | input | 1 | Write `host_wdata` into operand B at `host_addr` (idle only) |
| host_addr | input | 10 | Host word address for load and readback |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Result word read back, one cycle after address |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| lat_cycles | output | 12 | Cycles spent in the current/last run |

## Verification
The bench sweeps every element through four operand patterns:
- A ramp pair catches swapped or misrouted lanes and addresses.
- A pair whose sums all overflow to the same small value exposes any carry handling that differs from modulo 2^32.
- Alternating-bit words mixed with the index detect crossed data bits between the two memory ports.
- Multiplicative hash data makes every word distinct.

Each element's check is tagged by whether it belongs to the early or the late lane pair, so a fault in the delayed half of the split access shows separately from one in the first half. One run injects a stray start and a host write mid-run. A rerun without reloading then shows that neither reached the design.

// File: rtl/vadd_pkg.sv
package vadd_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_DRAIN = 2'd2,
        S_FIN   = 2'd3
    } vadd_state_t;

    localparam int MEM_PORTS = 2;
endpackage

// File: rtl/dp_ram.sv
module dp_ram #(
    parameter int DW    = 32,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we0,
    input  logic [AW-1:0] addr0,
    input  logic [DW-1:0] wd0,
    output logic [DW-1:0] rd0,
    input  logic          we1,
    input  logic [AW-1:0] addr1,
    input  logic [DW-1:0] wd1,
    output logic [DW-1:0] rd1
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we0) mem[addr0] <= wd0;
        if (we1) mem[addr1] <= wd1;
        rd0 <= mem[addr0];
        rd1 <= mem[addr1];
    end
endmodule

// File: rtl/pipe_adder.sv
module pipe_adder #(
    parameter int DW  = 32,
    parameter int TW  = 10,
    parameter int LAT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    input  logic [TW-1:0] in_tag,
    output logic          out_vld,
    output logic [DW-1:0] out_sum,
    output logic [TW-1:0] out_tag
);
    logic [LAT-1:0] v_q;
    logic [DW-1:0]  s_q [LAT];
    logic [TW-1:0]  t_q [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= '0;
        end else begin
            v_q[0] <= in_vld;
            for (int i = 1; i < LAT; i++) v_q[i] <= v_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        s_q[0] <= in_a + in_b;
        t_q[0] <= in_tag;
        for (int i = 1; i < LAT; i++) begin
            s_q[i] <= s_q[i-1];
            t_q[i] <= t_q[i-1];
        end
    end

    assign out_vld = v_q[LAT-1];
    assign out_sum = s_q[LAT-1];
    assign out_tag = t_q[LAT-1];
endmodule

// File: rtl/vadd_ctrl.sv
module vadd_ctrl
    import vadd_pkg::*;
#(
    parameter int ITERS    = 256,
    parameter int GROUPS   = 2,
    parameter int ITER_LAT = 11,
    localparam int IW = (ITERS > 1) ? $clog2(ITERS) : 1,
    localparam int PW = $clog2(ITER_LAT),
    localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int CW = $clog2(ITERS * ITER_LAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [PW-1:0] phase,
    output logic [IW-1:0] iter,
    output logic          issue,
    output logic [GW-1:0] issue_grp,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] lat_cycles
);
    vadd_state_t state, nxt;
    logic        iter_end, last_iter;

    assign iter_end  = (phase == PW'(ITER_LAT - 1));
    assign last_iter = (iter == IW'(ITERS - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = S_ISSUE;
            S_ISSUE: if (phase == PW'(GROUPS - 1)) nxt = S_DRAIN;
            S_DRAIN: if (iter_end) nxt = last_iter ? S_FIN : S_ISSUE;
            S_FIN:   nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // Iteration, phase and latency counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase      <= '0;
            iter       <= '0;
            lat_cycles <= '0;
        end else if (state == S_IDLE) begin
            if (start) begin
                phase      <= '0;
                iter       <= '0;
                lat_cycles <= '0;
            end
        end else if (state == S_ISSUE || state == S_DRAIN) begin
            lat_cycles <= lat_cycles + 1'b1;
            if (iter_end) begin
                phase <= '0;
                iter  <= iter + 1'b1;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        issue     = (state == S_ISSUE);
        issue_grp = phase[GW-1:0];
        busy      = (state == S_ISSUE) || (state == S_DRAIN);
        done      = (state == S_FIN);
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5
    AST_LAT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (lat_cycles == CW'(ITERS * ITER_LAT))); // R3
    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (busy || done)); // R6
endmodule

// File: rtl/lane4_vadd.sv
module lane4_vadd
    import vadd_pkg::*;
#(
    parameter int DW      = 32,
    parameter int DEPTH   = 1024,
    parameter int LANES   = 4,
    parameter int ADD_LAT = 8,
    localparam int AW       = $clog2(DEPTH),
    localparam int GROUPS   = LANES / MEM_PORTS,
    localparam int ITERS    = DEPTH / LANES,
    localparam int ITER_LAT = ADD_LAT + 1 + GROUPS,
    localparam int IW       = (ITERS > 1) ? $clog2(ITERS) : 1,
    localparam int PW       = $clog2(ITER_LAT),
    localparam int GW       = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int CW       = $clog2(ITERS * ITER_LAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          host_wr_a,
    input  logic          host_wr_b,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] lat_cycles
);
    logic [PW-1:0] phase;
    logic [IW-1:0] iter;
    logic          issue;
    logic [GW-1:0] issue_grp;

    vadd_ctrl #(.ITERS(ITERS), .GROUPS(GROUPS), .ITER_LAT(ITER_LAT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .phase(phase), .iter(iter), .issue(issue), .issue_grp(issue_grp),
        .busy(busy), .done(done), .lat_cycles(lat_cycles)
    );

    // Read address generation: one lane pair per issue cycle
    logic [AW-1:0] it_base;
    logic [AW-1:0] rd_addr [MEM_PORTS];

    always_comb begin
        it_base = AW'(32'(iter) * LANES);
        for (int p = 0; p < MEM_PORTS; p++)
            rd_addr[p] = it_base + AW'(32'(issue_grp) * MEM_PORTS + p);
    end

    logic          rd_vld_q;
    logic [GW-1:0] rd_grp_q;
    logic [AW-1:0] rd_base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_vld_q  <= 1'b0;
            rd_grp_q  <= '0;
            rd_base_q <= '0;
        end else begin
            rd_vld_q  <= issue;
            rd_grp_q  <= issue_grp;
            rd_base_q <= rd_addr[0];
        end
    end

    // Operand memories: port 0 shared with host when idle
    logic [DW-1:0] a_rd [MEM_PORTS];
    logic [DW-1:0] b_rd [MEM_PORTS];
    logic [AW-1:0] op_addr0;

    assign op_addr0 = busy ? rd_addr[0] : host_addr;

    dp_ram #(.DW(DW), .DEPTH(DEPTH)) u_mem_a (
        .clk(clk),
        .we0(host_wr_a && !busy), .addr0(op_addr0), .wd0(host_wdata), .rd0(a_rd[0]),
        .we1(1'b0), .addr1(rd_addr[1]), .wd1('0), .rd1(a_rd[1])
    );

    dp_ram #(.DW(DW), .DEPTH(DEPTH)) u_mem_b (
        .clk(clk),
        .we0(host_wr_b && !busy), .addr0(op_addr0), .wd0(host_wdata), .rd0(b_rd[0]),
        .we1(1'b0), .addr1(rd_addr[1]), .wd1('0), .rd1(b_rd[1])
    );

    // Adder lanes: lane g*2+p is fed by port p in issue cycle g
    logic [LANES-1:0] sum_vld;
    logic [DW-1:0]    sum_dat [LANES];
    logic [AW-1:0]    sum_tag [LANES];

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        for (genvar p = 0; p < MEM_PORTS; p++) begin : g_port
            localparam int L = g * MEM_PORTS + p;
            pipe_adder #(.DW(DW), .TW(AW), .LAT(ADD_LAT)) u_add (
                .clk(clk), .rst_n(rst_n),
                .in_vld(rd_vld_q && (rd_grp_q == GW'(g))),
                .in_a(a_rd[p]), .in_b(b_rd[p]),
                .in_tag(rd_base_q + AW'(p)),
                .out_vld(sum_vld[L]), .out_sum(sum_dat[L]), .out_tag(sum_tag[L])
            );
        end
    end

    // Result write steering: each port takes whichever lane pair is finishing
    logic [MEM_PORTS-1:0]             r_we;
    logic [AW-1:0]                    r_wa [MEM_PORTS];
    logic [DW-1:0]                    r_wd [MEM_PORTS];
    logic [MEM_PORTS-1:0][GROUPS-1:0] wsel;

    always_comb begin
        for (int p = 0; p < MEM_PORTS; p++) begin
            r_we[p] = 1'b0;
            r_wa[p] = '0;
            r_wd[p] = '0;
            for (int g = 0; g < GROUPS; g++) begin
                wsel[p][g] = sum_vld[g * MEM_PORTS + p];
                if (sum_vld[g * MEM_PORTS + p]) begin
                    r_we[p] = 1'b1;
                    r_wa[p] = sum_tag[g * MEM_PORTS + p];
                    r_wd[p] = sum_dat[g * MEM_PORTS + p];
                end
            end
        end
    end

    logic [DW-1:0] r_rd [MEM_PORTS];
    logic [AW-1:0] res_addr [MEM_PORTS];

    always_comb begin
        for (int p = 0; p < MEM_PORTS; p++)
            res_addr[p] = busy ? r_wa[p] : host_addr;
    end

    dp_ram #(.DW(DW), .DEPTH(DEPTH)) u_mem_r (
        .clk(clk),
        .we0(r_we[0]), .addr0(res_addr[0]), .wd0(r_wd[0]), .rd0(r_rd[0]),
        .we1(r_we[1]), .addr1(res_addr[1]), .wd1(r_wd[1]), .rd1(r_rd[1])
    );

    assign host_rdata = r_rd[0];

    AST_WR_SPLIT_P0: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(wsel[0])); // R4
    AST_WR_SPLIT_P1: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(wsel[1])); // R4
    AST_WR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) (|r_we) |-> (busy && phase >= PW'(ADD_LAT + 1))); // R3
    AST_READBACK_PORTS: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !done && $past(!busy)) |-> (r_rd[0] == r_rd[1])); // R10
endmodule

// File: tb/sim_lane4_vadd.sv
module sim_lane4_vadd;
    localparam int DW       = 32;
    localparam int DEPTH    = 1024;
    localparam int LANES    = 4;
    localparam int ADD_LAT  = 8;
    localparam int AW       = 10;
    localparam int ITERS    = DEPTH / LANES;
    localparam int ITER_LAT = ADD_LAT + 3;
    localparam int CW       = $clog2(ITERS * ITER_LAT + 1);
    localparam int RUN_LEN  = ITERS * ITER_LAT;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          host_wr_a = 1'b0;
    logic          host_wr_b = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          busy, done;
    logic [CW-1:0] lat_cycles;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] ea [DEPTH];
    logic [DW-1:0] eb [DEPTH];

    always #10 clk = ~clk;

    lane4_vadd #(.DW(DW), .DEPTH(DEPTH), .LANES(LANES), .ADD_LAT(ADD_LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .host_wr_a(host_wr_a), .host_wr_b(host_wr_b),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .busy(busy), .done(done), .lat_cycles(lat_cycles)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat_a(input int p, input int i);
        case (p)
            0: return DW'(i);
            1: return 32'hFFFF_FFFF - DW'(i);
            2: return (i % 2 == 1 ? 32'hAAAA_AAAA : 32'h5555_5555) ^ DW'(i);
            default: return DW'(i) * 32'h9E37_79B1;
        endcase
    endfunction

    function automatic logic [DW-1:0] pat_b(input int p, input int i);
        case (p)
            0: return DW'(3 * i + 7);
            1: return DW'(i + 5);
            2: return (DW'(i) << 20) ^ 32'h0F0F_0F0F;
            default: return (DW'(i) * 32'h85EB_CA6B) ^ 32'hDEAD_BEEF;
        endcase
    endfunction

    task automatic load(input int p);
        for (int i = 0; i < DEPTH; i++) begin
            ea[i] = pat_a(p, i);
            eb[i] = pat_b(p, i);
            @(negedge clk);
            host_addr = AW'(i); host_wdata = ea[i]; host_wr_a = 1'b1; host_wr_b = 1'b0;
            @(negedge clk);
            host_wdata = eb[i]; host_wr_a = 1'b0; host_wr_b = 1'b1;
        end
        @(negedge clk);
        host_wr_b = 1'b0;
    endtask

    // Runs once; poke = inject stray start (R6) and host write (R7) mid-run
    task automatic run(input bit poke);
        int n;
        bit busy_ok;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        busy_ok = busy;
        while (!done && n < 3 * RUN_LEN) begin
            @(negedge clk);
            n++;
            if (!done && !busy) busy_ok = 1'b0;
            if (poke && n == 500) start = 1'b1;
            if (poke && n == 501) start = 1'b0;
            if (poke && n == 600) begin
                host_addr = AW'(5); host_wdata = 32'hDEAD_0000; host_wr_a = 1'b1; host_wr_b = 1'b1;
            end
            if (poke && n == 601) begin
                host_wr_a = 1'b0; host_wr_b = 1'b0;
            end
        end
        chk(poke ? "R6 done timing" : "R5 done timing", DW'(n), DW'(RUN_LEN + 1));
        chk("R5 busy held", DW'(busy_ok), 32'd1);
        chk(poke ? "R6 latency" : "R3 latency", DW'(lat_cycles), DW'(RUN_LEN));
        @(negedge clk);
        chk("R5 done pulse", DW'(done), 32'd0);
        chk("R5 busy cleared", DW'(busy), 32'd0);
    endtask

    task automatic readback(input string tag);
        for (int i = 0; i < DEPTH; i++) begin
            host_addr = AW'(i);
            @(negedge clk);
            if (i % 4 >= 2) chk({tag, " R4 late pair"}, host_rdata, ea[i] + eb[i]);
            else            chk({tag, " R2 early pair"}, host_rdata, ea[i] + eb[i]);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy", DW'(busy), 32'd0);
        chk("R1 done", DW'(done), 32'd0);
        chk("R1 lat", DW'(lat_cycles), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int p = 0; p < 4; p++) begin
            load(p);
            run(p == 2);
            if (p == 1) readback("R8 wrap R10");
            else        readback("R10");
            if (p == 1) chk("R8 wrapped sum", ea[7] + eb[7], 32'd4);
            if (p == 2) begin
                run(1'b0);
                readback("R9 rerun");
                host_addr = AW'(5);
                @(negedge clk);
                chk("R7 busy write dropped", host_rdata, pat_a(2, 5) + pat_b(2, 5));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule